// File: doc/BRIEF.md
# Multi-Source Reset Supervisor Controller

This controller produces an active-low system reset from three digitised supply-good flags and a raw push-button input. Each flag can be excluded individually, so one design serves boards that watch one, two or three rails. Any enabled flag reporting a low supply, or an accepted button press, pulls the reset low. The reset is released only after a recovery timeout has elapsed with every condition clear. Two timeout lengths are available, picked by a static strap.

The button passes through a synchroniser and a glitch filter. A delayed mode can also be selected, in which the button must stay low for a programmable number of clock cycles before it acts. Every time is stated in physical units and converted to clock cycles from the clock-frequency parameter. The converted values are: recovery `floor(CLK_KHZ*us/1000)` cycles, glitch filter `ceil(CLK_KHZ*FILT_NS/1e6)` cycles (at least 1), and minimum hold `ceil(CLK_KHZ*HOLD_MIN_US/1000)` cycles (at least 1). Counter widths are sized so that 1.2 s always fits.

Top module: `reset_supervisor`

## Requirements
- R1: While `arst_n` is low, `rst_n` is 0. After `arst_n` rises with all enabled flags good and the button high, `rst_n` goes to 1 at the (2 + REC_S)-th rising clock edge, where REC_S is the short recovery length in cycles.
- R2: A bit of `pg` (1 = supply good) that is enabled in `pg_en` and falls to 0 drives `rst_n` to 0 at the third rising edge after the change, and not before.
- R3: A flag whose `pg_en` bit is 0 has no effect on `rst_n`.
- R4: With `rec_long` = 0, `rst_n` rises at the (2 + REC_S)-th edge after the last supply fault clears.
- R5: With `rec_long` = 1, the same release occurs after (2 + REC_L) edges, where REC_L is the long recovery length.
- R6: When faults overlap, release is timed from the last condition to clear and not from the first.
- R7: A low button level that lasts fewer than FILT synchronised cycles is ignored. A level held for FILT cycles is accepted, and `rst_n` falls at edge 2 + FILT + 1 after `btn_n` falls.
- R8: After an accepted press, `rst_n` stays 0 while the button is held. It rises 2 + FILT + REC edges after `btn_n` returns to 1.
- R9: When `dly_en` = 1, the filtered button must stay low for `hold_len` further cycles, so `rst_n` falls at edge 2 + FILT + hold + 1. Releasing the button early clears the hold count.
- R10: In delayed mode, a `hold_len` below the minimum hold time is raised to that minimum.
- R11: A fault arriving during the recovery countdown drives `rst_n` back to 0. The full countdown then restarts once all conditions clear again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous active-low reset of the logic |
| pg | input | NSUP | Asynchronous supply-good flags, 1 = good |
| pg_en | input | NSUP | Per-flag enable, 1 = flag is monitored |
| btn_n | input | 1 | Raw active-low push-button |
| dly_en | input | 1 | 1 = require a long hold before the press acts |
| hold_len | input | HOLD_W | Hold time in clock cycles for delayed mode |
| rec_long | input | 1 | Recovery select: 0 = short, 1 = long |
| rst_n | output | 1 | Active-low system reset |

## Verification
The bench targets several failure points:
- Filter length: a button low for one cycle less than the filter must leave the reset high. A design whose filter is one cycle short would reset on that glitch.
- Overlapping faults: the button is held after a supply fault has already cleared. A design that times release from the first cleared condition would let the reset go early.
- Delayed mode: one hold is interrupted and then followed by a full hold, which catches partial credit carried between presses. A very small hold setting checks that the minimum clamp is applied.
- Restart during countdown: a fault arrives mid-countdown. A design that resumes the old count instead of restarting it would release too soon.

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int CLK_KHZ      = 50000,
  parameter int REC_SHORT_US = 210000,
  parameter int REC_LONG_US  = 900000,
  parameter int FILT_NS      = 500,
  parameter int HOLD_MIN_US  = 6,
  parameter int NSUP         = 3,
  parameter int HOLD_W       = 28
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NSUP-1:0]   pg,
  input  logic [NSUP-1:0]   pg_en,
  input  logic              btn_n,
  input  logic              dly_en,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              rec_long,
  output logic              rst_n
);
  localparam longint KHZ      = longint'(CLK_KHZ);
  localparam int     REC_S    = int'((KHZ * REC_SHORT_US) / 1000);
  localparam int     REC_L    = int'((KHZ * REC_LONG_US) / 1000);
  localparam int     LIM_US   = (REC_LONG_US > 1200000) ? REC_LONG_US :
                                (REC_SHORT_US > 1200000) ? REC_SHORT_US : 1200000;
  localparam int     REC_W    = $clog2(int'((KHZ * LIM_US) / 1000) + 1);
  localparam longint FRAW     = (KHZ * FILT_NS + 999999) / 1000000;
  localparam int     FILT_CYC = (FRAW < 1) ? 1 : int'(FRAW);
  localparam int     FILT_W   = $clog2(FILT_CYC + 1);
  localparam longint HRAW     = (KHZ * HOLD_MIN_US + 999) / 1000;
  localparam int     HOLD_MIN = (HRAW < 1) ? 1 : int'(HRAW);

  logic [NSUP-1:0]   pg_m, pg_s;
  logic              mr_m, mr_s, mr_f;
  logic [FILT_W-1:0] flt_cnt;
  logic [HOLD_W-1:0] hcnt, hold_eff;
  logic [REC_W-1:0]  rcnt, rec_len;
  logic              press, pg_bad, fault;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      pg_m <= '0; pg_s <= '0;
      mr_m <= 1'b1; mr_s <= 1'b1;
    end else begin
      pg_m <= pg; pg_s <= pg_m;
      mr_m <= btn_n; mr_s <= mr_m;
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      mr_f <= 1'b1; flt_cnt <= '0;
    end else if (mr_s == mr_f) begin
      flt_cnt <= '0;
    end else if (flt_cnt == FILT_W'(FILT_CYC - 1)) begin
      mr_f <= mr_s; flt_cnt <= '0;
    end else begin
      flt_cnt <= flt_cnt + 1'b1;
    end

  assign hold_eff = (hold_len < HOLD_W'(HOLD_MIN)) ? HOLD_W'(HOLD_MIN) : hold_len;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)             hcnt <= '0;
    else if (mr_f)           hcnt <= '0;
    else if (hcnt < hold_eff) hcnt <= hcnt + 1'b1;

  assign press   = !mr_f && (!dly_en || hcnt >= hold_eff);
  assign pg_bad  = |(~pg_s & pg_en);
  assign fault   = pg_bad || press;
  assign rec_len = rec_long ? REC_W'(REC_L) : REC_W'(REC_S);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      rst_n <= 1'b0; rcnt <= '0;
    end else if (fault) begin
      rst_n <= 1'b0; rcnt <= '0;
    end else if (!rst_n) begin
      if (rcnt >= rec_len - REC_W'(1)) rst_n <= 1'b1;
      else                             rcnt  <= rcnt + 1'b1;
    end
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
  input logic        clk,
  input logic        arst_n,
  input logic        rst_n,
  input logic        pg_bad,
  input logic        press,
  input logic        mr_s,
  input logic        mr_f,
  input logic [31:0] hcnt,
  input logic [31:0] rec_len
);
  logic [32:0] quiet;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                     quiet <= '0;
    else if (pg_bad || press || rst_n) quiet <= '0;
    else                             quiet <= quiet + 1'b1;

  AST_SUPPLY_HOLDS_RESET: assert property (@(posedge clk) disable iff (!arst_n) pg_bad |=> !rst_n); // R2
  AST_BUTTON_HOLDS_RESET: assert property (@(posedge clk) disable iff (!arst_n) press |=> !rst_n); // R8
  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!arst_n) $rose(rst_n) |-> quiet >= {1'b0, rec_len}); // R4
  AST_RELEASE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!arst_n) $rose(rst_n) |-> (!$past(pg_bad) && !$past(press))); // R6
  AST_FILTER_STEADY: assert property (@(posedge clk) disable iff (!arst_n) (mr_s == mr_f) |=> $stable(mr_f)); // R7
  AST_HOLD_CLEARED: assert property (@(posedge clk) disable iff (!arst_n) mr_f |=> hcnt == 32'd0); // R9
endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .rst_n   (rst_n),
  .pg_bad  (pg_bad),
  .press   (press),
  .mr_s    (mr_s),
  .mr_f    (mr_f),
  .hcnt    (32'(hcnt)),
  .rec_len (32'(rec_len))
);

// File: tb/sim_reset_supervisor.sv
`timescale 1ns/1ps
module sim_reset_supervisor;
  localparam int KHZ = 10000, RS_US = 30, RL_US = 80, F_NS = 500, HM_US = 6, HW = 12;
  localparam int REC_S = KHZ * RS_US / 1000;
  localparam int REC_L = KHZ * RL_US / 1000;
  localparam int FLT   = (KHZ * F_NS + 999999) / 1000000;
  localparam int HMIN  = (KHZ * HM_US + 999) / 1000;

  logic clk = 0, arst_n = 0, btn_n = 1, dly_en = 0, rec_long = 0, rst_n;
  logic [2:0] pg = 3'b111, pg_en = 3'b111;
  logic [HW-1:0] hold_len = '0;
  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  reset_supervisor #(.CLK_KHZ(KHZ), .REC_SHORT_US(RS_US), .REC_LONG_US(RL_US),
    .FILT_NS(F_NS), .HOLD_MIN_US(HM_US), .NSUP(3), .HOLD_W(HW)) u0 (
    .clk(clk), .arst_n(arst_n), .pg(pg), .pg_en(pg_en), .btn_n(btn_n),
    .dly_en(dly_en), .hold_len(hold_len), .rec_long(rec_long), .rst_n(rst_n));

  int bq[$];
  logic [2:0] pq[$];
  int filt, run, held, cnt, heff, bs, ofilt;
  logic [2:0] ps;
  logic exp_rst, prs, flt;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bq = '{1, 1}; pq = '{3'b000, 3'b000};
      filt = 1; run = 0; held = 0; cnt = 0; exp_rst = 0;
    end else begin
      bs = bq.pop_front(); bq.push_back(int'(btn_n));
      ps = pq.pop_front(); pq.push_back(pg);
      heff = (int'(hold_len) < HMIN) ? HMIN : int'(hold_len);
      prs = (filt == 0) && (!dly_en || held >= heff);
      flt = ((~ps & pg_en) != 3'b000) || prs;
      ofilt = filt;
      if (bs != filt) begin
        run++;
        if (run == FLT) begin filt = bs; run = 0; end
      end else run = 0;
      if (ofilt == 1) held = 0;
      else if (held < heff) held++;
      if (flt) begin exp_rst = 0; cnt = 0; end
      else if (!exp_rst) begin
        cnt++;
        if (cnt >= (rec_long ? REC_L : REC_S)) exp_rst = 1;
      end
    end
  end

  always @(negedge clk)
    if (arst_n) begin
      compared++;
      if (rst_n !== exp_rst) begin
        mismatched++;
        $display("FAIL %s model compare actual=%0d expected=%0d", cur_req, rst_n, exp_rst);
      end
    end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cnt_until(logic want, output int n);
    n = 0;
    while (rst_n !== want && n < 5000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic highs_for(int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (rst_n === 1'b1) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n, h;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 held during logic reset", rst_n, 0);
    arst_n = 1;
    cnt_until(1, n);
    chk("R1 first release", n, 2 + REC_S);

    cur_req = "R2";
    pg[1] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet low after 2 edges", rst_n, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 low at third edge", rst_n, 0);
    cur_req = "R4";
    pg[1] = 1;
    cnt_until(1, n);
    chk("R4 short recovery", n, 2 + REC_S);

    cur_req = "R3";
    pg_en = 3'b011; pg[2] = 0;
    highs_for(20, h);
    chk("R3 disabled flag ignored", h, 20);
    pg[2] = 1; pg_en = 3'b111;
    repeat (5) @(negedge clk);

    cur_req = "R5";
    rec_long = 1; pg[0] = 0;
    repeat (4) @(negedge clk);
    pg[0] = 1;
    cnt_until(1, n);
    chk("R5 long recovery", n, 2 + REC_L);
    rec_long = 0;

    cur_req = "R6";
    pg[0] = 0;
    repeat (10) @(negedge clk);
    btn_n = 0;
    repeat (10) @(negedge clk);
    pg[0] = 1;
    repeat (50) @(negedge clk);
    chk("R6 held by button after supply clears", rst_n, 0);
    btn_n = 1;
    cnt_until(1, n);
    chk("R6 release timed from last condition", n, 2 + FLT + REC_S);

    cur_req = "R7";
    btn_n = 0;
    repeat (FLT - 1) @(negedge clk);
    btn_n = 1;
    highs_for(30, h);
    chk("R7 short glitch ignored", h, 30);
    btn_n = 0;
    cnt_until(0, n);
    chk("R7 press accepted", n, 2 + FLT + 1);
    btn_n = 1;
    cnt_until(1, n);
    chk("R7 release after press", n, 2 + FLT + REC_S);

    cur_req = "R8";
    btn_n = 0;
    repeat (400) @(negedge clk);
    chk("R8 low while held", rst_n, 0);
    btn_n = 1;
    cnt_until(1, n);
    chk("R8 recovery after release", n, 2 + FLT + REC_S);

    cur_req = "R9";
    dly_en = 1; hold_len = HW'(100);
    btn_n = 0;
    repeat (80) @(negedge clk);
    btn_n = 1;
    highs_for(40, h);
    chk("R9 short hold ignored", h, 40);
    btn_n = 0;
    repeat (80) @(negedge clk);
    btn_n = 1;
    repeat (10) @(negedge clk);
    chk("R9 no partial credit", rst_n, 1);
    btn_n = 0;
    cnt_until(0, n);
    chk("R9 full hold accepted", n, 2 + FLT + 100 + 1);
    btn_n = 1;
    cnt_until(1, n);
    chk("R9 release after hold", n, 2 + FLT + REC_S);

    cur_req = "R10";
    hold_len = HW'(3);
    btn_n = 0;
    cnt_until(0, n);
    chk("R10 hold clamped to minimum", n, 2 + FLT + HMIN + 1);
    btn_n = 1;
    cnt_until(1, n);
    dly_en = 0;

    cur_req = "R11";
    pg[1] = 0;
    repeat (4) @(negedge clk);
    pg[1] = 1;
    repeat (150) @(negedge clk);
    chk("R11 still counting", rst_n, 0);
    pg[2] = 0;
    repeat (3) @(negedge clk);
    pg[2] = 1;
    cnt_until(1, n);
    chk("R11 countdown restarted", n, 2 + REC_S);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule